// File: doc/BRIEF.md
# Serial Peripheral Select and Backlight Decoder

This block sits behind a synchronous serial port that is shared by three peripherals: a display timing controller handled locally, a touch-panel converter and a monitoring ADC. Each peripheral has its own active-low chip select. A received word is routed to every peripheral whose select is low. Read data comes back through a fixed-priority multiplexer.

The display timing controller is the only peripheral decoded inside the block. Each 8-bit command word carries a 3-bit register address in its upper bits and a 5-bit value in its lower bits. One register loads the low five bits of a 6-bit backlight intensity. Another register picks between a high-resolution and a low-resolution display mode.

The top bit of the intensity and the backlight power enable come from two separate discrete lines. The block outputs the effective intensity, which is forced to zero while power is off. It also outputs a backlight-on flag and a one-cycle update strobe. The two external converters are not part of the block.

Top module: `psb_top`

## Requirements
- R1: After reset the stored intensity is 0x20 and backlight power is off. `blLevel`, `blOn`, `lowResMode` and `blUpdate` are all 0. Turning power on with `blDimN` low then gives `blLevel` = 0x20.
- R2: `touchWrEn` is high exactly when `wrValid` is high and `csTouchN` is low. `adcWrEn` is high exactly when `wrValid` is high and `csAdcN` is low. Both may be high in the same cycle as a display command, so one write is broadcast to all selected peripherals.
- R3: `rdData` is combinational and follows this priority:
  - 0 if `csDispN` is low;
  - otherwise `touchRdData` if `csTouchN` is low;
  - otherwise `adcRdData` if `csAdcN` is low;
  - otherwise 0.
- R4: A display command is split as address = bits 7:5 and value = bits 4:0. A command with address 2 replaces intensity bits 4:0 with the value. Intensity bit 5 is not affected.
- R5: A command with address 0 sets `lowResMode` to 1 when the value is non-zero, and to 0 when the value is zero.
- R6: Commands with any address other than 0 and 2 leave `blLevel`, `blOn` and `lowResMode` unchanged and raise no strobe.
- R7: Intensity bit 5 is 0 while `blDimN` is high and 1 while it is low.
- R8: `blLevel` and `blOn` are 0 whenever power is off. While power is on, `blLevel` equals the intensity, and `blOn` is 0 when the intensity is zero.
- R9: Every change of the backlight power line gives a `blUpdate` pulse, whether power turns on or off.
- R10: An intensity change gives a `blUpdate` pulse only while power is on. Writing a value equal to the current intensity gives no pulse. Each pulse lasts one cycle.
- R11: A display command takes effect only in a cycle where `wrValid` is high and `csDispN` is low.
- R12: `blLevel`, `blOn`, `lowResMode` and `blUpdate` are registered. They reflect the inputs of a cycle after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csDispN | input | 1 | Display controller select, active low |
| csTouchN | input | 1 | Touch converter select, active low |
| csAdcN | input | 1 | Monitoring ADC select, active low |
| wrValid | input | 1 | A received word is present this cycle |
| wrData | input | 8 | Received word |
| touchRdData | input | 16 | Read data from the touch converter |
| adcRdData | input | 16 | Read data from the ADC |
| touchWrEn | output | 1 | Write enable to the touch converter |
| adcWrEn | output | 1 | Write enable to the ADC |
| rdData | output | 16 | Read data returned to the serial port |
| blDimN | input | 1 | Discrete line; high clears intensity bit 5 |
| blPowerOn | input | 1 | Backlight power enable |
| blLevel | output | 6 | Effective backlight intensity |
| blOn | output | 1 | Backlight powered and intensity non-zero |
| blUpdate | output | 1 | One-cycle pulse on a backlight change |
| lowResMode | output | 1 | Display in low-resolution mode |

## Verification
The bench selects several peripherals at once and checks the following:
- Writes must reach every selected slave. A decoder that picked only one slave would drop the touch or ADC enable.
- Reads must give zero whenever the display is selected. A design with the wrong priority would leak converter data.
- An intensity write while power is off must produce no strobe. Restoring power must produce a strobe and show the stored value. A design that gated the register instead of the output would lose the value written while off.
- A command with an unused address, or one sent without the display select, must change nothing. A sloppy address decode would corrupt the duty value or the resolution flag.

// File: rtl/psb_pkg.sv
package psb_pkg;
  parameter int ADDR_W = 3;
  parameter int VAL_W  = 5;
  localparam int CMD_W   = ADDR_W + VAL_W;
  localparam int LEVEL_W = VAL_W + 1;

  typedef struct packed {
    logic             dutyWr;
    logic             resWr;
    logic [VAL_W-1:0] val;
  } cmdStrobe_t;
endpackage

// File: rtl/psb_ctrl.sv
module psb_ctrl
  import psb_pkg::*;
#(
  parameter int RD_W      = 16,
  parameter int DUTY_ADDR = 2,
  parameter int RES_ADDR  = 0
) (
  input  logic             csDispN,
  input  logic             csTouchN,
  input  logic             csAdcN,
  input  logic             wrValid,
  input  logic [CMD_W-1:0] wrData,
  input  logic [RD_W-1:0]  touchRdData,
  input  logic [RD_W-1:0]  adcRdData,
  output logic             touchWrEn,
  output logic             adcWrEn,
  output logic [RD_W-1:0]  rdData,
  output cmdStrobe_t       cmdStb
);
  logic [ADDR_W-1:0] cmdAddr;
  logic              dispWr;

  assign cmdAddr = wrData[CMD_W-1:VAL_W];
  assign dispWr  = wrValid && !csDispN;

  // Broadcast: each selected slave gets the same word.
  assign touchWrEn = wrValid && !csTouchN;
  assign adcWrEn   = wrValid && !csAdcN;

  always_comb begin
    cmdStb.val    = wrData[VAL_W-1:0];
    cmdStb.dutyWr = dispWr && (cmdAddr == ADDR_W'(DUTY_ADDR));
    cmdStb.resWr  = dispWr && (cmdAddr == ADDR_W'(RES_ADDR));
  end

  // Fixed-priority read return; the display side has nothing to send back.
  always_comb begin
    if (!csDispN)       rdData = '0;
    else if (!csTouchN) rdData = touchRdData;
    else if (!csAdcN)   rdData = adcRdData;
    else                rdData = '0;
  end
endmodule

// File: rtl/psb_dpath.sv
module psb_dpath
  import psb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cmdStrobe_t         cmdStb,
  input  logic               blDimN,
  input  logic               blPowerOn,
  output logic [LEVEL_W-1:0] blLevel,
  output logic               blOn,
  output logic               blUpdate,
  output logic               lowResMode
);
  localparam logic [LEVEL_W-1:0] INT_RESET = {1'b1, {VAL_W{1'b0}}};

  logic [VAL_W-1:0]   dutyQ, dutyNxt;
  logic               topQ, topNxt;
  logic               powQ;
  logic [LEVEL_W-1:0] intCur, intNxt;

  assign dutyNxt = cmdStb.dutyWr ? cmdStb.val : dutyQ;
  assign topNxt  = !blDimN;
  assign intCur  = {topQ, dutyQ};
  assign intNxt  = {topNxt, dutyNxt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyQ      <= INT_RESET[VAL_W-1:0];
      topQ       <= INT_RESET[LEVEL_W-1];
      powQ       <= 1'b0;
      lowResMode <= 1'b0;
      blLevel    <= '0;
      blOn       <= 1'b0;
      blUpdate   <= 1'b0;
    end else begin
      dutyQ    <= dutyNxt;
      topQ     <= topNxt;
      powQ     <= blPowerOn;
      if (cmdStb.resWr) lowResMode <= (cmdStb.val != '0);
      blLevel  <= blPowerOn ? intNxt : '0;
      blOn     <= blPowerOn && (intNxt != '0);
      blUpdate <= (blPowerOn != powQ) || (blPowerOn && (intNxt != intCur));
    end
  end
endmodule

// File: rtl/psb_top.sv
module psb_top
  import psb_pkg::*;
#(
  parameter int RD_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csDispN,
  input  logic               csTouchN,
  input  logic               csAdcN,
  input  logic               wrValid,
  input  logic [CMD_W-1:0]   wrData,
  input  logic [RD_W-1:0]    touchRdData,
  input  logic [RD_W-1:0]    adcRdData,
  output logic               touchWrEn,
  output logic               adcWrEn,
  output logic [RD_W-1:0]    rdData,
  input  logic               blDimN,
  input  logic               blPowerOn,
  output logic [LEVEL_W-1:0] blLevel,
  output logic               blOn,
  output logic               blUpdate,
  output logic               lowResMode
);
  cmdStrobe_t cmdStb;

  psb_ctrl #(.RD_W(RD_W)) u_ctrl (
    .csDispN(csDispN), .csTouchN(csTouchN), .csAdcN(csAdcN),
    .wrValid(wrValid), .wrData(wrData),
    .touchRdData(touchRdData), .adcRdData(adcRdData),
    .touchWrEn(touchWrEn), .adcWrEn(adcWrEn), .rdData(rdData),
    .cmdStb(cmdStb)
  );

  psb_dpath u_dpath (
    .clk(clk), .rstN(rstN), .cmdStb(cmdStb),
    .blDimN(blDimN), .blPowerOn(blPowerOn),
    .blLevel(blLevel), .blOn(blOn), .blUpdate(blUpdate),
    .lowResMode(lowResMode)
  );
endmodule

// File: rtl/psb_checker.sv
module psb_checker
  import psb_pkg::*;
#(
  parameter int RD_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               csDispN,
  input logic               wrValid,
  input logic               touchWrEn,
  input logic               adcWrEn,
  input logic [RD_W-1:0]    rdData,
  input logic               blDimN,
  input logic               blPowerOn,
  input logic [LEVEL_W-1:0] blLevel,
  input logic               blOn,
  input logic               blUpdate,
  input logic               lowResMode
);
  a_r2_no_wr_without_valid: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> (!touchWrEn && !adcWrEn));

  a_r3_disp_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !csDispN |-> (rdData == '0));

  a_r8_on_needs_level: assert property (@(posedge clk) disable iff (!rstN)
    (blLevel == '0) |-> !blOn);

  a_r7_top_bit: assert property (@(posedge clk) disable iff (!rstN)
    blPowerOn |=> (blLevel[LEVEL_W-1] == !$past(blDimN)));

  a_r9_power_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (blPowerOn != $past(blPowerOn))) |=> blUpdate);

  a_r10_quiet_unpowered: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !blPowerOn && !$past(blPowerOn)) |=> !blUpdate);

  a_r11_res_hold: assert property (@(posedge clk) disable iff (!rstN)
    (csDispN || !wrValid) |=> $stable(lowResMode));
endmodule

bind psb_top psb_checker #(.RD_W(RD_W)) u_chk (
  .clk(clk), .rstN(rstN), .csDispN(csDispN), .wrValid(wrValid),
  .touchWrEn(touchWrEn), .adcWrEn(adcWrEn), .rdData(rdData),
  .blDimN(blDimN), .blPowerOn(blPowerOn), .blLevel(blLevel),
  .blOn(blOn), .blUpdate(blUpdate), .lowResMode(lowResMode)
);

// File: tb/psb_top_bench.sv
`timescale 1ns/1ps
module psb_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csDispN = 1'b1, csTouchN = 1'b1, csAdcN = 1'b1;
  logic        wrValid = 1'b0;
  logic [7:0]  wrData = '0;
  logic [15:0] touchRdData = 16'h1234, adcRdData = 16'h5678;
  logic        touchWrEn, adcWrEn;
  logic [15:0] rdData;
  logic        blDimN = 1'b0, blPowerOn = 1'b0;
  logic [5:0]  blLevel;
  logic        blOn, blUpdate, lowResMode;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psb_top u_psb_top (
    .clk(clk), .rstN(rstN), .csDispN(csDispN), .csTouchN(csTouchN),
    .csAdcN(csAdcN), .wrValid(wrValid), .wrData(wrData),
    .touchRdData(touchRdData), .adcRdData(adcRdData),
    .touchWrEn(touchWrEn), .adcWrEn(adcWrEn), .rdData(rdData),
    .blDimN(blDimN), .blPowerOn(blPowerOn), .blLevel(blLevel),
    .blOn(blOn), .blUpdate(blUpdate), .lowResMode(lowResMode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendCmd(input logic [2:0] addr, input logic [4:0] val);
    csDispN = 1'b0; wrValid = 1'b1; wrData = {addr, val};
    tick();
    csDispN = 1'b1; wrValid = 1'b0;
  endtask

  task automatic test_reset();
    check("R1 level", blLevel, 6'h00);
    check("R1 on", blOn, 1'b0);
    check("R1 res", lowResMode, 1'b0);
    check("R1 upd", blUpdate, 1'b0);
    blPowerOn = 1'b1; tick();
    check("R1 reset intensity", blLevel, 6'h20);
    check("R9 power-on strobe", blUpdate, 1'b1);
    tick();
    check("R10 strobe one cycle", blUpdate, 1'b0);
    check("R12 level held", blLevel, 6'h20);
  endtask

  task automatic test_duty();
    sendCmd(3'd2, 5'h15);
    check("R4 duty low bits", blLevel, 6'h35);
    check("R10 change strobe", blUpdate, 1'b1);
    sendCmd(3'd2, 5'h15);
    check("R10 same value no strobe", blUpdate, 1'b0);
  endtask

  task automatic test_ignored();
    sendCmd(3'd5, 5'h1f);
    check("R6 addr5 level", blLevel, 6'h35);
    check("R6 addr5 res", lowResMode, 1'b0);
    check("R6 addr5 upd", blUpdate, 1'b0);
    sendCmd(3'd1, 5'h07);
    check("R6 addr1 level", blLevel, 6'h35);
    check("R6 addr1 on", blOn, 1'b1);
  endtask

  task automatic test_resolution();
    sendCmd(3'd0, 5'h03);
    check("R5 low res", lowResMode, 1'b1);
    check("R5 level kept", blLevel, 6'h35);
    sendCmd(3'd0, 5'h00);
    check("R5 high res", lowResMode, 1'b0);
  endtask

  task automatic test_no_select();
    csDispN = 1'b1; wrValid = 1'b1; wrData = {3'd2, 5'h01};
    tick();
    check("R11 no select", blLevel, 6'h35);
    csDispN = 1'b0; wrValid = 1'b0; wrData = {3'd0, 5'h01};
    tick();
    csDispN = 1'b1;
    check("R11 no valid level", blLevel, 6'h35);
    check("R11 no valid res", lowResMode, 1'b0);
  endtask

  task automatic test_top_bit();
    blDimN = 1'b1; tick();
    check("R7 dim high clears bit5", blLevel, 6'h15);
    check("R10 bit5 strobe", blUpdate, 1'b1);
    blDimN = 1'b0; tick();
    check("R7 dim low sets bit5", blLevel, 6'h35);
  endtask

  task automatic test_gating();
    blDimN = 1'b1;
    sendCmd(3'd2, 5'h00);
    check("R8 zero intensity level", blLevel, 6'h00);
    check("R8 zero intensity off", blOn, 1'b0);
    blDimN = 1'b0;
    sendCmd(3'd2, 5'h0a);
    check("R4 restore", blLevel, 6'h2a);
    blPowerOn = 1'b0; tick();
    check("R8 power off level", blLevel, 6'h00);
    check("R8 power off on", blOn, 1'b0);
    check("R9 power-off strobe", blUpdate, 1'b1);
    sendCmd(3'd2, 5'h1f);
    check("R10 unpowered no strobe", blUpdate, 1'b0);
    check("R8 unpowered level", blLevel, 6'h00);
    blPowerOn = 1'b1; tick();
    check("R8 stored while off", blLevel, 6'h3f);
    check("R9 power-on again", blUpdate, 1'b1);
  endtask

  task automatic test_route();
    csTouchN = 1'b0; csAdcN = 1'b0; csDispN = 1'b0; wrValid = 1'b1;
    wrData = {3'd2, 5'h11};
    #1;
    check("R2 touch en", touchWrEn, 1'b1);
    check("R2 adc en", adcWrEn, 1'b1);
    tick();
    check("R2 display also written", blLevel, 6'h31);
    wrValid = 1'b0; csDispN = 1'b1;
    #1;
    check("R2 touch idle", touchWrEn, 1'b0);
    check("R2 adc idle", adcWrEn, 1'b0);
    csTouchN = 1'b1; wrValid = 1'b1;
    #1;
    check("R2 touch deselected", touchWrEn, 1'b0);
    check("R2 adc alone", adcWrEn, 1'b1);
    wrValid = 1'b0; csAdcN = 1'b1;
  endtask

  task automatic test_read();
    #1;
    check("R3 none", rdData, 16'h0000);
    csAdcN = 1'b0; #1;
    check("R3 adc", rdData, 16'h5678);
    csTouchN = 1'b0; #1;
    check("R3 touch over adc", rdData, 16'h1234);
    csDispN = 1'b0; #1;
    check("R3 display wins zero", rdData, 16'h0000);
    csDispN = 1'b1; csTouchN = 1'b1; csAdcN = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    test_reset();
    test_duty();
    test_ignored();
    test_resolution();
    test_no_select();
    test_top_bit();
    test_gating();
    test_route();
    test_read();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule